// File: doc/BRIEF.md
# Stack Element Address Generator

This block works out the address of a stack element for a stack kept in ordinary memory. The stack grows from higher addresses toward lower ones. Its pointer is a 15-bit address held in a memory word, and that pointer always names the most recent entry. An operation starts with a one-cycle strobe that carries three things: a 2-bit access mode, the address of the pointer word, and the signed X register. The block reads the pointer word through a single-port synchronous memory port and forms the element address. In the two stack-moving modes it writes the updated pointer back. When the element address is ready it raises a one-cycle done pulse, and the address stays on its output for the datapath to use.

Four modes are provided. Direct uses the pointer as it is. Indexed adds X, read as a signed number, to the pointer and clears the top bit of the sum. Pop uses the current pointer and stores the pointer plus one. Push stores the pointer minus one and uses that lowered value. The block does not check the stack against any bound, and it does not perform the access to the element itself.

Top module: `stack_ea_unit`

## Requirements
- R1: With mode 2'b00 (direct), the element address is bits 14..0 of the fetched pointer word, and no memory write takes place.
- R2: With mode 2'b01 (indexed), the element address is bits 14..0 of the 16-bit sum of the pointer word and X, both taken as two's complement. No memory write takes place.
- R3: With mode 2'b10 (pop), the element address is bits 14..0 of the fetched pointer, and the pointer plus one is written back to the pointer word.
- R4: With mode 2'b11 (push), the pointer minus one is written back to the pointer word, and the element address is bits 14..0 of that lowered value.
- R5: Bit 15 of the pointer address is ignored. The pointer read and the write-back both use bits 14..0 of the pointer address.
- R6: The pointer increment and decrement wrap modulo 2^16: 16'hFFFF plus one gives 16'h0000, and 16'h0000 minus one gives 16'hFFFF. No limit is checked.
- R7: The pointer read is issued in the cycle after start is sampled. The read and the write never happen in the same cycle. Done is a single-cycle pulse. It comes 2 cycles after the read cycle for direct and indexed, and 3 cycles after it for pop and push, with the write in the cycle before done.
- R8: A start that arrives while an operation is in progress is ignored: there is no extra read, no extra write and no extra done. A start in the done cycle begins a new operation.
- R9: While reset is active and right after it, done, the read enable and the write enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle or in the done cycle) |
| mode | input | 2 | 00 direct, 01 indexed, 10 pop, 11 push |
| ptr_addr | input | DATA_W | Address of the pointer word (bit 15 ignored) |
| x_reg | input | DATA_W | Signed index value |
| mem_addr | output | DATA_W-1 | Memory word address |
| mem_re | output | 1 | Memory read enable (data returned one cycle later) |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Write data (updated pointer) |
| mem_rdata | input | DATA_W | Read data |
| ea | output | DATA_W-1 | Effective stack element address |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with the default DATA_W of 16. At that width the 15-bit address boundary and the 16-bit wrap are both reachable with short vectors. Pointers of 16'hFFFF and 16'h0000 exercise the wrap in both directions. A pointer with bit 15 set, and a pointer of 16'h7FFF plus one, show that the top bit of the sum is dropped. Pointer addresses with bit 15 set confirm that the memory sees only the low 15 bits.

// File: rtl/stack_ea_pkg.sv
// Package: shared mode and state encodings for the stack element address unit.
// Assumes: the mode encoding is fixed by the requirements (00/01/10/11).
package stack_ea_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT  = 2'b00,
        MODE_INDEXED = 2'b01,
        MODE_POP     = 2'b10,
        MODE_PUSH    = 2'b11
    } sea_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_EVAL  = 3'd2,
        ST_WBACK = 3'd3,
        ST_DONE  = 3'd4
    } sea_state_e;

endpackage

// File: rtl/stack_ea_arith.sv
// Module: stack_ea_arith
// Purely combinational address arithmetic. From the fetched pointer word,
// the captured mode and X, it forms the next element address, the pointer
// value to store back, and whether a store is needed.
// Assumes: DATA_W >= 2; the element address drops the top bit of the word.
module stack_ea_arith
    import stack_ea_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  sea_mode_e          mode_q,
    input  logic [DATA_W-1:0]  ptr_word,
    input  logic [DATA_W-1:0]  x_word,
    output logic [DATA_W-2:0]  ea_next,
    output logic [DATA_W-1:0]  ptr_next,
    output logic               wb_needed
);
    localparam int EA_W = DATA_W - 1;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] ptr_inc;
    logic [DATA_W-1:0] ptr_dec;
    logic [DATA_W-1:0] ptr_sum;

    // Candidate results, all wrapping modulo 2^DATA_W.
    always_comb begin
        ptr_inc = ptr_word + ONE;
        ptr_dec = ptr_word - ONE;
        ptr_sum = ptr_word + x_word;
    end

    // Mode select for address, store-back value and store request.
    always_comb begin
        ea_next   = ptr_word[EA_W-1:0];
        ptr_next  = ptr_word;
        wb_needed = 1'b0;
        case (mode_q)
            MODE_DIRECT: begin
                ea_next = ptr_word[EA_W-1:0];
            end
            MODE_INDEXED: begin
                ea_next = ptr_sum[EA_W-1:0];
            end
            MODE_POP: begin
                ea_next   = ptr_word[EA_W-1:0];
                ptr_next  = ptr_inc;
                wb_needed = 1'b1;
            end
            MODE_PUSH: begin
                ea_next   = ptr_dec[EA_W-1:0];
                ptr_next  = ptr_dec;
                wb_needed = 1'b1;
            end
            default: begin
                ea_next = ptr_word[EA_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/stack_ea_fsm.sv
// Module: stack_ea_fsm
// Sequencer. It captures the request, reads the pointer word, latches the
// computed address and store-back value, performs the optional store, and
// pulses done.
// Assumes: memory read data is valid one cycle after mem_re; a start is
// accepted only in the idle or done state.
module stack_ea_fsm
    import stack_ea_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         mode,
    input  logic [DATA_W-1:0]  ptr_addr,
    input  logic [DATA_W-1:0]  x_reg,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic [DATA_W-2:0]  ea_next,
    input  logic [DATA_W-1:0]  ptr_next,
    input  logic               wb_needed,
    output sea_mode_e          mode_q,
    output logic [DATA_W-1:0]  x_q,
    output logic [DATA_W-2:0]  mem_addr,
    output logic               mem_re,
    output logic               mem_we,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [DATA_W-2:0]  ea,
    output logic               done
);
    localparam int EA_W = DATA_W - 1;
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    sea_state_e        state;
    logic [EA_W-1:0]   addr_q;
    logic [EA_W-1:0]   ea_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept;

    // A new request is taken only when no operation is in flight.
    always_comb begin
        accept = start && ((state == ST_IDLE) || (state == ST_DONE));
    end

    // State sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  state <= accept ? ST_FETCH : ST_IDLE;
                ST_FETCH: state <= ST_EVAL;
                ST_EVAL:  state <= wb_needed ? ST_WBACK : ST_DONE;
                ST_WBACK: state <= ST_DONE;
                ST_DONE:  state <= accept ? ST_FETCH : ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Request capture; the top bit of the pointer address is discarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_DIRECT;
            addr_q <= '0;
            x_q    <= '0;
        end else if (accept) begin
            mode_q <= sea_mode_e'(mode);
            addr_q <= ptr_addr[EA_W-1:0];
            x_q    <= x_reg;
        end
    end

    // Result capture in the cycle the pointer word arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q    <= '0;
            wdata_q <= '0;
        end else if (state == ST_EVAL) begin
            ea_q    <= ea_next;
            wdata_q <= ptr_next;
        end
    end

    // Memory port and completion outputs decoded from state.
    always_comb begin
        mem_re    = (state == ST_FETCH);
        mem_we    = (state == ST_WBACK);
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        ea        = ea_q;
        done      = (state == ST_DONE);
    end

    // R1/R2: only the stack-moving modes may write.
    p_write_only_moving_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mode_q[1]);

    // R3: pop stores the fetched pointer plus one.
    p_pop_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mode_q == MODE_POP) |-> (mem_wdata == $past(mem_rdata) + ONE));

    // R4: push stores the fetched pointer minus one.
    p_push_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mode_q == MODE_PUSH) |-> (mem_wdata == $past(mem_rdata) - ONE));

    // R5: the read goes to the low bits of the address given with start.
    p_read_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (mem_addr == $past(ptr_addr[EA_W-1:0])));

    // R7: read and write never overlap; done is one cycle wide.
    p_port_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: one read per operation; a busy start does not trigger a second.
    p_single_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);

endmodule

// File: rtl/stack_ea_unit.sv
// Module: stack_ea_unit (top)
// Stack element address unit for a downward-growing stack whose pointer is
// held in memory. It joins the sequencer and the address arithmetic.
// Assumes: a single-port synchronous memory with one-cycle read latency.
module stack_ea_unit
    import stack_ea_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         mode,
    input  logic [DATA_W-1:0]  ptr_addr,
    input  logic [DATA_W-1:0]  x_reg,
    output logic [DATA_W-2:0]  mem_addr,
    output logic               mem_re,
    output logic               mem_we,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-2:0]  ea,
    output logic               done
);
    localparam int EA_W = DATA_W - 1;

    sea_mode_e         mode_q;
    logic [DATA_W-1:0] x_q;
    logic [EA_W-1:0]   ea_next;
    logic [DATA_W-1:0] ptr_next;
    logic              wb_needed;

    stack_ea_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode      (mode),
        .ptr_addr  (ptr_addr),
        .x_reg     (x_reg),
        .mem_rdata (mem_rdata),
        .ea_next   (ea_next),
        .ptr_next  (ptr_next),
        .wb_needed (wb_needed),
        .mode_q    (mode_q),
        .x_q       (x_q),
        .mem_addr  (mem_addr),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .ea        (ea),
        .done      (done)
    );

    stack_ea_arith #(.DATA_W(DATA_W)) u_arith (
        .mode_q    (mode_q),
        .ptr_word  (mem_rdata),
        .x_word    (x_q),
        .ea_next   (ea_next),
        .ptr_next  (ptr_next),
        .wb_needed (wb_needed)
    );

    // R9: nothing is requested of memory and done stays low in reset.
    p_quiet_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (!done && !mem_re && !mem_we));

endmodule

// File: tb/test_stack_ea_unit.sv
`timescale 1ns/1ps
module test_stack_ea_unit;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] paddr;
        logic [15:0] pval;
        logic [15:0] x;
        logic [14:0] ea;
        logic        wr;
        logic [15:0] wval;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 16'h0010, 16'h1234, 16'h0000, 15'h1234, 1'b0, 16'h1234}, // R1
        '{2'b00, 16'h8011, 16'h9ABC, 16'h0000, 15'h1ABC, 1'b0, 16'h9ABC}, // R1 R5
        '{2'b01, 16'h0012, 16'h0100, 16'h0005, 15'h0105, 1'b0, 16'h0100}, // R2
        '{2'b01, 16'h0013, 16'h0100, 16'hFFFE, 15'h00FE, 1'b0, 16'h0100}, // R2 neg X
        '{2'b01, 16'h0017, 16'h8005, 16'h0003, 15'h0008, 1'b0, 16'h8005}, // R2 neg ptr
        '{2'b01, 16'h0018, 16'h7FFF, 16'h0001, 15'h0000, 1'b0, 16'h7FFF}, // R2 top cleared
        '{2'b10, 16'h0014, 16'h2000, 16'h0000, 15'h2000, 1'b1, 16'h2001}, // R3
        '{2'b11, 16'h0015, 16'h2000, 16'h0000, 15'h1FFF, 1'b1, 16'h1FFF}, // R4
        '{2'b10, 16'h0019, 16'hFFFF, 16'h0000, 15'h7FFF, 1'b1, 16'h0000}, // R6
        '{2'b11, 16'h001A, 16'h0000, 16'h0000, 15'h7FFF, 1'b1, 16'hFFFF}, // R6
        '{2'b11, 16'h8016, 16'h0001, 16'h0000, 15'h0000, 1'b1, 16'h0000}  // R4 R5
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic [1:0]  mode = 0;
    logic [15:0] ptr_addr = 0;
    logic [15:0] x_reg = 0;
    logic [14:0] mem_addr;
    logic        mem_re, mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 0;
    logic [14:0] ea;
    logic        done;

    logic [15:0] mem [256];
    int          wr_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    stack_ea_unit i_stack_ea_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .ptr_addr(ptr_addr), .x_reg(x_reg), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ea(ea), .done(done)
    );

    // Synchronous memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] m, input logic [15:0] pa, input logic [15:0] xv,
                          input bit poke, output int cyc, output bit rd_ok, output logic [14:0] ea_o);
        mode = m; ptr_addr = pa; x_reg = xv; start = 1;
        cyc = 0; rd_ok = 0; ea_o = '0;
        while (cyc < 20) begin
            @(negedge clk);
            cyc++;
            start = 0;
            if (cyc == 1) begin
                rd_ok = mem_re && !mem_we && (mem_addr == pa[14:0]);
                if (poke) begin
                    start = 1; mode = 2'b11; ptr_addr = 16'h0021;
                end
            end
            if (done) begin
                ea_o = ea;
                break;
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cyc;
        bit rd_ok;
        logic [14:0] got;
        int w0;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!done && !mem_re && !mem_we, "R9 reset outputs", {done, mem_re, mem_we}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!done && !mem_re && !mem_we, "R9 after reset", {done, mem_re, mem_we}, 0);

        for (int v = 0; v < NV; v++) begin
            mem[VECS[v].paddr[7:0]] = VECS[v].pval;
            w0 = wr_cnt;
            run_op(VECS[v].mode, VECS[v].paddr, VECS[v].x, 1'b0, cyc, rd_ok, got);
            chk(rd_ok, "R5 R7 read addr/cycle", 32'(mem_addr), 32'(VECS[v].paddr[14:0]));
            chk(got == VECS[v].ea, "R1-4 ea (vector)", 32'(got), 32'(VECS[v].ea));
            chk(cyc == (VECS[v].wr ? 4 : 3), "R7 latency", cyc, VECS[v].wr ? 4 : 3);
            chk((wr_cnt - w0) == (VECS[v].wr ? 1 : 0), "R1 R3 R4 write count", wr_cnt - w0, VECS[v].wr ? 1 : 0);
            chk(mem[VECS[v].paddr[7:0]] == VECS[v].wval, "R3 R4 R6 pointer word", 32'(mem[VECS[v].paddr[7:0]]), 32'(VECS[v].wval));
        end
        @(negedge clk);
        chk(!done, "R7 done single pulse", done, 0);

        // R3 R4 chained push then pop, started in the done cycle
        mem[8'h30] = 16'h0500;
        run_op(2'b11, 16'h0030, 16'h0, 1'b0, cyc, rd_ok, got);
        chk(got == 15'h04FF && mem[8'h30] == 16'h04FF, "R4 chained push", 32'(got), 32'h04FF);
        run_op(2'b10, 16'h0030, 16'h0, 1'b0, cyc, rd_ok, got);
        chk(got == 15'h04FF && mem[8'h30] == 16'h0500, "R3 chained pop", 32'(mem[8'h30]), 32'h0500);
        chk(cyc == 4, "R8 start in done cycle accepted", cyc, 4);

        // R8 start while busy is ignored
        @(negedge clk);
        mem[8'h20] = 16'h3000;
        mem[8'h21] = 16'h4444;
        w0 = wr_cnt;
        run_op(2'b10, 16'h0020, 16'h0, 1'b1, cyc, rd_ok, got);
        chk(got == 15'h3000 && cyc == 4, "R8 busy op result", 32'(got), 32'h3000);
        begin
            int extra = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (done || mem_re) extra++;
            end
            chk(extra == 0, "R8 no extra activity", extra, 0);
        end
        chk(wr_cnt - w0 == 1 && mem[8'h21] == 16'h4444, "R8 ignored push untouched", 32'(mem[8'h21]), 32'h4444);
        chk(mem[8'h20] == 16'h3001, "R3 busy op store", 32'(mem[8'h20]), 32'h3001);

        // R9 reset mid-operation
        mode = 2'b11; ptr_addr = 16'h0020; start = 1;
        @(negedge clk);
        start = 0; rst_n = 0;
        @(negedge clk);
        chk(!done && !mem_re && !mem_we, "R9 reset mid-op", {done, mem_re, mem_we}, 0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk(!done && mem[8'h20] == 16'h3001, "R9 aborted op no store", 32'(mem[8'h20]), 32'h3001);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule